// File: doc/BRIEF.md
# Per-Row DRAM Address Multiplexer

This block turns a host byte address into the multiplexed address that a DRAM row is driven with. The row that the address falls in has already been chosen elsewhere. That row's configuration comes in beside the address and has three parts: whether the row holds SDRAM or EDO parts, a code for its column-bit count, and whether its devices are the small (16 Mb) or the large (64 Mb) density. From that configuration the block works out, row by row, where the column field ends, how many bank-select bits follow it, and how wide the row field is.

A phase input tells the block which half of the access is being presented. In the row phase the 14-line bus carries the row field. In the column phase it carries the column field. The bank-select bits are driven in both phases. The block also reports the page size that applies to the row, which controller logic can use for its open-page bookkeeping. Command sequencing and timing belong to the surrounding controller. All outputs are registered.

Top module: `dram_addr_mux`

## Requirements
- R1: Every output (`ma`, `ba`, `page_code`) reflects the inputs sampled at one rising clock edge and changes only at that edge, so results appear one cycle after the inputs are applied.
- R2: While `rst_n` is low at a rising edge, `ma`, `ba` and `page_code` become zero.
- R3: The column field is the run of address bits starting at bit 3. For SDRAM rows it is 8 bits wide for `col_code` 0, 9 bits for code 1, and 10 bits for codes 2 and 3. For EDO rows it is always 8 bits. In the column phase (`col_phase` = 1), `ma` carries this field and every line above it is 0.
- R4: For SDRAM rows the bank field sits directly above the column field. It is 1 bit wide for 16 Mb rows (`dev_64mb` = 0, so `ba[1]` is 0) and 2 bits wide for 64 Mb rows. For EDO rows there is no bank field and `ba` is 0.
- R5: The row field sits directly above the bank field, or directly above the column field for EDO rows. It is 12 bits wide for 16 Mb rows, which leaves `ma[13:12]` at 0, and 14 bits wide for 64 Mb rows. In the row phase (`col_phase` = 0), `ma` carries this field.
- R6: `page_code` is 0 for a 2 KB page, 1 for a 4 KB page and 2 for an 8 KB page. An SDRAM row with 8, 9 or 10 column bits gives 0, 1 or 2 respectively. An EDO row always gives 0, whatever its `col_code`. The value 3 never appears.
- R7: Address bits 2..0, and every address bit above the row field, have no effect on any output.
- R8: Changing only `col_phase` changes only `ma`. `ba` and `page_code` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 32 | Host byte address within the selected row |
| col_phase | input | 1 | 1 selects the column phase, 0 selects the row phase |
| row_is_sdram | input | 1 | 1 for an SDRAM row, 0 for an EDO row |
| col_code | input | 2 | Column-bit count code: 0 means 8 bits, 1 means 9 bits, 2 or 3 means 10 bits |
| dev_64mb | input | 1 | 1 for 64 Mb devices, 0 for 16 Mb devices |
| ma | output | 14 | Multiplexed memory address lines |
| ba | output | 2 | Bank-select bits |
| page_code | output | 2 | Page size in effect for the row: 0 is 2 KB, 1 is 4 KB, 2 is 8 KB |

## Verification
Every result (`ma`, `ba` and `page_code`) is due exactly one rising edge after the inputs that produce it. The bench therefore drives inputs on the falling edge and reads the outputs 1 ns after the next rising edge. Between those two points, one directed test reads the outputs again after the inputs have changed but before the edge, to confirm that the old values are still there. Reset is checked the same way: outputs are read one edge after `rst_n` is sampled low, with non-zero inputs applied.

// File: rtl/dram_addr_mux_pkg.sv
// dram_addr_mux_pkg
// Shared widths, the page-size encoding and the decoded row geometry used
// by the address multiplexer. Assumes an 8-byte data path.
package dram_addr_mux_pkg;

    localparam int HADDR_W_D   = 32;  // host byte-address width
    localparam int MA_W_D      = 14;  // multiplexed address lines
    localparam int BA_W_D      = 2;   // bank-select lines
    localparam int LANE_LSB_D  = 3;   // byte-lane bits dropped (8-byte path)
    localparam int COL_MIN     = 8;   // narrowest column field
    localparam int ROW_SMALL   = 12;  // row bits of the small density
    localparam int ROW_LARGE   = 14;  // row bits of the large density
    localparam int CNT_W       = 4;   // width of a field-size count
    localparam int LSB_W       = 6;   // width of a field start position

    // page size in effect for a row
    typedef enum logic [1:0] {
        PG_2K = 2'd0,
        PG_4K = 2'd1,
        PG_8K = 2'd2
    } page_e;

    // decoded per-row address geometry
    typedef struct packed {
        logic [CNT_W-1:0] n_col;
        logic [CNT_W-1:0] n_bank;
        logic [CNT_W-1:0] n_row;
        page_e            page;
    } geom_t;

endpackage

// File: rtl/dram_addr_geom.sv
// dram_addr_geom
// Decodes one row's configuration into field widths and the page size.
// Assumes: EDO rows use an 8-bit column with no bank bits, SDRAM column
// codes 2 and 3 both mean 10 bits, and the row width follows the density.
module dram_addr_geom
    import dram_addr_mux_pkg::*;
(
    input  logic       row_is_sdram,
    input  logic [1:0] col_code,
    input  logic       dev_64mb,
    output geom_t      geom
);

    // work out column/bank/row widths and the page size for this row
    always_comb begin
        geom.n_row = dev_64mb ? CNT_W'(ROW_LARGE) : CNT_W'(ROW_SMALL);
        if (row_is_sdram) begin
            geom.n_bank = dev_64mb ? CNT_W'(2) : CNT_W'(1);
            unique case (col_code)
                2'd0: begin
                    geom.n_col = CNT_W'(COL_MIN);
                    geom.page  = PG_2K;
                end
                2'd1: begin
                    geom.n_col = CNT_W'(COL_MIN + 1);
                    geom.page  = PG_4K;
                end
                default: begin
                    geom.n_col = CNT_W'(COL_MIN + 2);
                    geom.page  = PG_8K;
                end
            endcase
        end else begin
            geom.n_bank = '0;
            geom.n_col  = CNT_W'(COL_MIN);
            geom.page   = PG_2K;
        end
    end

endmodule

// File: rtl/dram_addr_slice.sv
// dram_addr_slice
// Extracts a variable-width field from an address, starting at a variable
// bit position, and zero-fills the output bits above the field width.
// Assumes width <= OUT_W.
module dram_addr_slice #(
    parameter int ADDR_W = 32,
    parameter int OUT_W  = 14,
    parameter int POS_W  = 6,
    parameter int CNT_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [POS_W-1:0]  start,
    input  logic [CNT_W-1:0]  width,
    output logic [OUT_W-1:0]  field
);

    logic [OUT_W-1:0] window;

    // bring the field down to bit 0
    assign window = OUT_W'(addr >> start);

    // keep only the bits inside the field width
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        assign field[i] = (CNT_W'(i) < width) ? window[i] : 1'b0;
    end

endmodule

// File: rtl/dram_addr_outreg.sv
// dram_addr_outreg
// Output register stage for the multiplexed address, the bank bits and
// the page code. Synchronous active-low reset clears every output.
module dram_addr_outreg #(
    parameter int MA_W = 14,
    parameter int BA_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MA_W-1:0] ma_d,
    input  logic [BA_W-1:0] ba_d,
    input  logic [1:0]      pg_d,
    output logic [MA_W-1:0] ma_q,
    output logic [BA_W-1:0] ba_q,
    output logic [1:0]      pg_q
);

    // capture next outputs, or clear them in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ma_q <= '0;
            ba_q <= '0;
            pg_q <= '0;
        end else begin
            ma_q <= ma_d;
            ba_q <= ba_d;
            pg_q <= pg_d;
        end
    end

endmodule

// File: rtl/dram_addr_mux.sv
// dram_addr_mux
// Per-row DRAM address multiplexer. It splits a host byte address into
// column, bank and row fields using the selected row's configuration, and
// drives either the row or the column field onto the multiplexed bus,
// according to the phase. Assumes the row select, command and timing
// logic lives outside. Outputs are registered (one cycle).
module dram_addr_mux
    import dram_addr_mux_pkg::*;
#(
    parameter int HADDR_W  = HADDR_W_D,
    parameter int MA_W     = MA_W_D,
    parameter int BA_W     = BA_W_D,
    parameter int LANE_LSB = LANE_LSB_D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               col_phase,
    input  logic               row_is_sdram,
    input  logic [1:0]         col_code,
    input  logic               dev_64mb,
    output logic [MA_W-1:0]    ma,
    output logic [BA_W-1:0]    ba,
    output logic [1:0]         page_code
);

    geom_t            geom;
    logic [LSB_W-1:0] col_lsb;
    logic [LSB_W-1:0] bank_lsb;
    logic [LSB_W-1:0] row_lsb;
    logic [MA_W-1:0]  col_field;
    logic [MA_W-1:0]  row_field;
    logic [BA_W-1:0]  bank_field;
    logic [MA_W-1:0]  ma_next;

    dram_addr_geom u_geom (
        .row_is_sdram (row_is_sdram),
        .col_code     (col_code),
        .dev_64mb     (dev_64mb),
        .geom         (geom)
    );

    // field start positions: column, then bank, then row
    always_comb begin
        col_lsb  = LSB_W'(LANE_LSB);
        bank_lsb = col_lsb + LSB_W'(geom.n_col);
        row_lsb  = bank_lsb + LSB_W'(geom.n_bank);
    end

    dram_addr_slice #(
        .ADDR_W (HADDR_W), .OUT_W (MA_W), .POS_W (LSB_W), .CNT_W (CNT_W)
    ) u_col (
        .addr (host_addr), .start (col_lsb), .width (geom.n_col),
        .field (col_field)
    );

    dram_addr_slice #(
        .ADDR_W (HADDR_W), .OUT_W (BA_W), .POS_W (LSB_W), .CNT_W (CNT_W)
    ) u_bank (
        .addr (host_addr), .start (bank_lsb), .width (geom.n_bank),
        .field (bank_field)
    );

    dram_addr_slice #(
        .ADDR_W (HADDR_W), .OUT_W (MA_W), .POS_W (LSB_W), .CNT_W (CNT_W)
    ) u_row (
        .addr (host_addr), .start (row_lsb), .width (geom.n_row),
        .field (row_field)
    );

    // pick the field for the current phase
    assign ma_next = col_phase ? col_field : row_field;

    dram_addr_outreg #(
        .MA_W (MA_W), .BA_W (BA_W)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .ma_d  (ma_next),
        .ba_d  (bank_field),
        .pg_d  (geom.page),
        .ma_q  (ma),
        .ba_q  (ba),
        .pg_q  (page_code)
    );

endmodule

// File: rtl/dram_addr_mux_chk.sv
// dram_addr_mux_chk
// Property checker bound to dram_addr_mux. Observes ports only.
module dram_addr_mux_chk #(
    parameter int HADDR_W = 32,
    parameter int MA_W    = 14,
    parameter int BA_W    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HADDR_W-1:0] host_addr,
    input logic               col_phase,
    input logic               row_is_sdram,
    input logic [1:0]         col_code,
    input logic               dev_64mb,
    input logic [MA_W-1:0]    ma,
    input logic [BA_W-1:0]    ba,
    input logic [1:0]         page_code
);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ma == '0 && ba == '0 && page_code == 2'd0));

    // R6
    page_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_code != 2'd3);

    // R4
    edo_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !row_is_sdram |=> (ba == '0 && page_code == 2'd0));

    // R4
    small_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_64mb |=> !ba[1]);

    // R3
    col8_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_phase && (!row_is_sdram || col_code == 2'd0)) |=> ma[MA_W-1:8] == '0);

    // R5
    row12_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_phase && !dev_64mb) |=> ma[MA_W-1:12] == '0);

    // R8
    phase_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(host_addr) && $stable(row_is_sdram)
         && $stable(col_code) && $stable(dev_64mb))
        |=> ($stable(ba) && $stable(page_code)));

endmodule

bind dram_addr_mux dram_addr_mux_chk #(
    .HADDR_W (HADDR_W), .MA_W (MA_W), .BA_W (BA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .col_phase    (col_phase),
    .row_is_sdram (row_is_sdram),
    .col_code     (col_code),
    .dev_64mb     (dev_64mb),
    .ma           (ma),
    .ba           (ba),
    .page_code    (page_code)
);

// File: tb/dram_addr_mux_bench.sv
// Self-checking bench for dram_addr_mux: a vector table, then directed tests.
module dram_addr_mux_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] host_addr;
    logic        col_phase;
    logic        row_is_sdram;
    logic [1:0]  col_code;
    logic        dev_64mb;
    logic [13:0] ma;
    logic [1:0]  ba;
    logic [1:0]  page_code;

    int n_checks = 0;
    int n_errs   = 0;

    always #4 clk = ~clk;  // 125 MHz

    dram_addr_mux u_dram_addr_mux (
        .clk (clk), .rst_n (rst_n), .host_addr (host_addr),
        .col_phase (col_phase), .row_is_sdram (row_is_sdram),
        .col_code (col_code), .dev_64mb (dev_64mb),
        .ma (ma), .ba (ba), .page_code (page_code)
    );

    // entry: sdram, code, d64, phase, row[14], bank[2], col[10], low[3]
    localparam int NV = 12;
    localparam logic [33:0] VEC [NV] = '{
        {1'b1, 2'd0, 1'b0, 1'b0, 14'h0ABC, 2'd1, 10'h05A, 3'd5},
        {1'b1, 2'd0, 1'b0, 1'b1, 14'h0ABC, 2'd1, 10'h05A, 3'd2},
        {1'b1, 2'd1, 1'b1, 1'b0, 14'h3A5C, 2'd2, 10'h1F3, 3'd7},
        {1'b1, 2'd1, 1'b1, 1'b1, 14'h3A5C, 2'd2, 10'h1F3, 3'd0},
        {1'b1, 2'd2, 1'b1, 1'b0, 14'h1234, 2'd3, 10'h3FF, 3'd1},
        {1'b1, 2'd2, 1'b1, 1'b1, 14'h1234, 2'd3, 10'h3FF, 3'd6},
        {1'b1, 2'd2, 1'b0, 1'b1, 14'h0FFF, 2'd1, 10'h200, 3'd3},
        {1'b1, 2'd3, 1'b1, 1'b0, 14'h0F0F, 2'd2, 10'h155, 3'd4},
        {1'b0, 2'd2, 1'b1, 1'b0, 14'h2222, 2'd0, 10'h0C3, 3'd7},
        {1'b0, 2'd1, 1'b0, 1'b1, 14'h0555, 2'd0, 10'h07E, 3'd1},
        {1'b1, 2'd1, 1'b0, 1'b0, 14'h0800, 2'd0, 10'h100, 3'd0},
        {1'b1, 2'd0, 1'b1, 1'b1, 14'h3FFF, 2'd3, 10'h0FF, 3'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // field widths taken from R3, R4, R5
    function automatic int ncol_of(input logic sd, input logic [1:0] code);
        if (!sd) return 8;
        return (code == 2'd0) ? 8 : (code == 2'd1) ? 9 : 10;
    endfunction
    function automatic int nbank_of(input logic sd, input logic d64);
        return !sd ? 0 : (d64 ? 2 : 1);
    endfunction
    function automatic int nrow_of(input logic d64);
        return d64 ? 14 : 12;
    endfunction
    // page encoding from R6
    function automatic logic [1:0] page_of(input logic sd, input logic [1:0] code);
        if (!sd) return 2'd0;
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction

    // build a host address from fields; bits above the row field set (R7)
    function automatic logic [31:0] compose(input logic sd, input logic [1:0] code,
            input logic d64, input logic [13:0] row, input logic [1:0] bank,
            input logic [9:0] col, input logic [2:0] low);
        int nc = ncol_of(sd, code);
        int nb = nbank_of(sd, d64);
        int top = 3 + nc + nb + nrow_of(d64);
        logic [31:0] a;
        a = {29'd0, low} | (32'(col) << 3) | (32'(bank) << (3 + nc))
            | (32'(row) << (3 + nc + nb));
        if (top < 32) a = a | ~((32'd1 << top) - 32'd1);
        return a;
    endfunction

    task automatic drive(input logic sd, input logic [1:0] code, input logic d64,
                         input logic ph, input logic [31:0] a);
        @(negedge clk);
        row_is_sdram = sd; col_code = code; dev_64mb = d64;
        col_phase = ph; host_addr = a;
    endtask

    task automatic finish_run;
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [13:0] s_ma;
        logic [1:0]  s_ba;
        logic [1:0]  s_pg;
        rst_n = 1'b0;
        host_addr = 32'hFFFF_FFF8; col_phase = 1'b1; row_is_sdram = 1'b1;
        col_code = 2'd2; dev_64mb = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R2: outputs zero in reset despite non-zero inputs
        check("R2 ma in reset", 32'(ma), 32'd0);
        check("R2 ba in reset", 32'(ba), 32'd0);
        check("R2 page in reset", 32'(page_code), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            logic        sd   = VEC[i][33];
            logic [1:0]  code = VEC[i][32:31];
            logic        d64  = VEC[i][30];
            logic        ph   = VEC[i][29];
            logic [13:0] row  = VEC[i][28:15];
            logic [1:0]  bank = VEC[i][14:13];
            logic [9:0]  col  = VEC[i][12:3];
            logic [2:0]  low  = VEC[i][2:0];
            drive(sd, code, d64, ph, compose(sd, code, d64, row, bank, col, low));
            @(posedge clk); #1;
            if (ph) check("R3 column-phase ma", 32'(ma), 32'(col));
            else    check("R5 row-phase ma", 32'(ma), 32'(row));
            check("R4 bank bits", 32'(ba), sd ? 32'(bank) : 32'd0);
            check("R6 page code", 32'(page_code), 32'(page_of(sd, code)));
        end

        // R1: output holds until the edge, then updates
        drive(1'b1, 2'd0, 1'b0, 1'b1, compose(1'b1, 2'd0, 1'b0, 14'h123, 2'd1, 10'h0AA, 3'd0));
        @(posedge clk); #1;
        s_ma = ma;
        @(negedge clk);
        host_addr = compose(1'b1, 2'd0, 1'b0, 14'h456, 2'd0, 10'h055, 3'd0);
        #1;
        check("R1 ma before edge", 32'(ma), 32'(s_ma));
        check("R1 ba before edge", 32'(ba), 32'd1);
        @(posedge clk); #1;
        check("R1 ma after edge", 32'(ma), 32'h055);
        check("R1 ba after edge", 32'(ba), 32'd0);

        // R7: only the low byte-lane bits differ
        drive(1'b1, 2'd1, 1'b1, 1'b0, compose(1'b1, 2'd1, 1'b1, 14'h2AB, 2'd3, 10'h111, 3'd0));
        @(posedge clk); #1;
        s_ma = ma; s_ba = ba;
        drive(1'b1, 2'd1, 1'b1, 1'b0, compose(1'b1, 2'd1, 1'b1, 14'h2AB, 2'd3, 10'h111, 3'd7));
        @(posedge clk); #1;
        check("R7 low bits ignored ma", 32'(ma), 32'(s_ma));
        check("R7 low bits ignored ba", 32'(ba), 32'(s_ba));

        // R8: phase toggle changes only ma
        s_ba = ba; s_pg = page_code;
        @(negedge clk);
        col_phase = 1'b1;
        @(posedge clk); #1;
        check("R8 ma to column", 32'(ma), 32'h111);
        check("R8 ba held", 32'(ba), 32'(s_ba));
        check("R8 page held", 32'(page_code), 32'(s_pg));

        // R6: EDO row with the widest column code still reports 2 KB
        drive(1'b0, 2'd3, 1'b1, 1'b1, compose(1'b0, 2'd3, 1'b1, 14'h1, 2'd0, 10'h0FF, 3'd0));
        @(posedge clk); #1;
        check("R6 EDO page", 32'(page_code), 32'd0);
        check("R3 EDO 8-bit column", 32'(ma), 32'h0FF);

        // R2: reset in mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R2 mid-run ma", 32'(ma), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end

endmodule